// File: doc/BRIEF.md
# Static Neighbourhood Pattern Fault Test Sequencer

This block drives a bit-organised RAM array through a test for static neighbourhood pattern sensitive faults. Each neighbourhood has five cells: a base cell and the cells directly above, below, left and right of it. Each cell gets a label, (column + 2*row) mod 5. Label 0 marks base cells, and labels 3, 2, 4 and 1 mark the up, down, left and right neighbours of a base cell. No base cell is a neighbour of another, so one pass over the array addresses every neighbourhood at the same time.

For base value 0 and then base value 1, the sequencer first writes the whole array: base cells get the base value and all other cells get 0. It then steps the four neighbour bits through a 16-entry Gray sequence. Before each new pattern it writes only the cells of the neighbour class whose bit changed. After each pattern it reads back every base cell and compares it with the base value. The first mismatch sets a sticky fail flag and latches the cell address and the pattern tag.

The RAM is assumed to return read data one cycle after a read strobe, and reads are assumed not to disturb any cell.

Top module: `npsf_seq`

## Requirements
- R1: After reset, done, fail, wrEn and rdEn are all 0.
- R2: A cell is a base cell when (col + 2*row) mod 5 is 0. Its neighbours are the cells at row-1 (pattern bit 0), row+1 (bit 1), col-1 (bit 2) and col+1 (bit 3).
- R3: On start, and again when the base value changes, every cell is written exactly once: base cells get the current base value and all other cells get 0.
- R4: For pattern index p from 0 to 15, the four neighbour bits of every base cell equal p ^ (p >> 1) when that base cell is read. Every base cell is read exactly once per pattern.
- R5: Moving from pattern p-1 to p writes only the cells of the one neighbour class whose bit changed. A run therefore makes 2*(cells + sum over p of that class's cell count) writes.
- R6: All 16 patterns run with base value 0 first, then all 16 run with base value 1, and every read expects the current base value.
- R7: rdEn is asserted only on base cells and never in the same cycle as wrEn. rdData is compared one cycle after rdEn.
- R8: On the first read mismatch, fail goes to 1, and failRow, failCol and failPat = {base value, pattern index} capture that read. Later mismatches leave the captured values unchanged. fail stays set until the next start.
- R9: done rises once the last compare has been made, holds with no memory strobes, and clears on the cycle after a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a test run when idle |
| rowAddr | output | RW | Row address to the array |
| colAddr | output | CW | Column address to the array |
| wrEn | output | 1 | Write strobe |
| wrData | output | 1 | Write data bit |
| rdEn | output | 1 | Read strobe |
| rdData | input | 1 | Read data, valid one cycle after rdEn |
| done | output | 1 | Run finished |
| fail | output | 1 | A mismatch was seen in this run |
| failRow | output | RW | Row of the first mismatch |
| failCol | output | CW | Column of the first mismatch |
| failPat | output | 5 | {base value, pattern index} of the first mismatch |

## Verification
The bench builds a 5x5 array, the smallest grid whose labels tile evenly, so each neighbour class holds exactly five cells. At this size every base cell is checked against every one of the 32 base/pattern pairs, and the expected write and read totals of a whole run follow directly from those class sizes. Seeded faults then cover the mismatch path: a pattern-dependent flip that appears only under neighbour pattern 1111, a base cell stuck at 1, and a base cell stuck at 0. Together they exercise both base values, a non-zero pattern index, and clearing between runs.

// File: rtl/npsf_pkg.sv
package npsf_pkg;
  typedef struct packed {
    logic       restart;
    logic       clearFail;
    logic       step;
    logic       doWrite;
    logic       doRead;
    logic       allCells;
    logic       wrBit;
    logic       baseBit;
    logic [2:0] selLabel;
    logic [3:0] patIdx;
  } strobes_t;

  function automatic logic [2:0] addMod5(input logic [2:0] a, input logic [2:0] b);
    logic [3:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= 4'd5) ? 3'(s - 4'd5) : s[2:0];
  endfunction
endpackage

// File: rtl/npsf_ctrl.sv
module npsf_ctrl
  import npsf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     lastCell,
  output strobes_t st,
  output logic     done
);
  typedef enum logic [2:0] {S_IDLE, S_INIT, S_READ, S_NBR, S_DRAIN} state_t;

  state_t     state;
  logic       baseBit;
  logic [3:0] patIdx;
  logic [1:0] slot;
  logic [3:0] gray;

  always_comb begin
    gray = patIdx ^ (patIdx >> 1);
    if (patIdx[0])      slot = 2'd0;
    else if (patIdx[1]) slot = 2'd1;
    else if (patIdx[2]) slot = 2'd2;
    else                slot = 2'd3;
  end

  always_comb begin
    st = '0;
    st.baseBit = baseBit;
    st.patIdx  = patIdx;
    st.wrBit   = gray[slot];
    case (slot)
      2'd0:    st.selLabel = 3'd3;
      2'd1:    st.selLabel = 3'd2;
      2'd2:    st.selLabel = 3'd4;
      default: st.selLabel = 3'd1;
    endcase
    case (state)
      S_IDLE: begin
        st.restart   = start;
        st.clearFail = start;
      end
      S_INIT: begin
        st.step = 1'b1; st.doWrite = 1'b1; st.allCells = 1'b1;
      end
      S_READ: begin
        st.step = 1'b1; st.doRead = 1'b1;
      end
      S_NBR: begin
        st.step = 1'b1; st.doWrite = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      baseBit <= 1'b0;
      patIdx  <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state   <= S_INIT;
          baseBit <= 1'b0;
          patIdx  <= '0;
          done    <= 1'b0;
        end
        S_INIT: if (lastCell) state <= S_READ;
        S_READ: if (lastCell) begin
          if (patIdx == 4'd15) begin
            patIdx <= '0;
            if (!baseBit) begin
              baseBit <= 1'b1;
              state   <= S_INIT;
            end else begin
              state <= S_DRAIN;
            end
          end else begin
            patIdx <= patIdx + 4'd1;
            state  <= S_NBR;
          end
        end
        S_NBR: if (lastCell) state <= S_READ;
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!st.doWrite && !st.doRead));
  a_r5_nbr_step_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_NBR) |-> (patIdx != 4'd0));
  a_r6_base_rises_after_full_sweep: assert property (@(posedge clk) disable iff (!rstN)
    $rose(baseBit) |-> ($past(patIdx) == 4'd15 && $past(state) == S_READ));
endmodule

// File: rtl/npsf_dp.sv
module npsf_dp
  import npsf_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 20,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
)(
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic          rdData,
  output logic [RW-1:0] rowAddr,
  output logic [CW-1:0] colAddr,
  output logic          wrEn,
  output logic          wrData,
  output logic          rdEn,
  output logic          lastCell,
  output logic          fail,
  output logic [RW-1:0] failRow,
  output logic [CW-1:0] failCol,
  output logic [4:0]    failPat
);
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [2:0]    label, rowLabel;
  logic          isBase;
  logic          pend, expBit;
  logic [RW-1:0] pRow;
  logic [CW-1:0] pCol;
  logic [4:0]    pPat;

  always_comb begin
    isBase   = (label == 3'd0);
    lastCell = (row == RW'(ROWS - 1)) && (col == CW'(COLS - 1));
    rowAddr  = row;
    colAddr  = col;
    wrEn     = st.doWrite && (st.allCells || label == st.selLabel);
    wrData   = st.allCells ? (isBase && st.baseBit) : st.wrBit;
    rdEn     = st.doRead && isBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row <= '0; col <= '0; label <= '0; rowLabel <= '0;
    end else if (st.restart) begin
      row <= '0; col <= '0; label <= '0; rowLabel <= '0;
    end else if (st.step) begin
      if (col == CW'(COLS - 1)) begin
        col <= '0;
        if (row == RW'(ROWS - 1)) begin
          row <= '0; label <= '0; rowLabel <= '0;
        end else begin
          row      <= row + 1'b1;
          rowLabel <= addMod5(rowLabel, 3'd2);
          label    <= addMod5(rowLabel, 3'd2);
        end
      end else begin
        col   <= col + 1'b1;
        label <= addMod5(label, 3'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= 1'b0; expBit <= 1'b0; pRow <= '0; pCol <= '0; pPat <= '0;
      fail <= 1'b0; failRow <= '0; failCol <= '0; failPat <= '0;
    end else begin
      pend   <= rdEn;
      expBit <= st.baseBit;
      pRow   <= row;
      pCol   <= col;
      pPat   <= {st.baseBit, st.patIdx};
      if (st.clearFail) begin
        fail <= 1'b0; failRow <= '0; failCol <= '0; failPat <= '0;
      end else if (pend && (rdData != expBit) && !fail) begin
        fail    <= 1'b1;
        failRow <= pRow;
        failCol <= pCol;
        failPat <= pPat;
      end
    end
  end

  a_r7_no_rw_clash: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn));
  a_r2_read_on_base: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (((int'(colAddr) + 2 * int'(rowAddr)) % 5) == 0));
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !st.clearFail) |=> fail);
  a_r8_capture_stable: assert property (@(posedge clk) disable iff (!rstN)
    (fail && !st.clearFail) |=> ($stable(failPat) && $stable(failRow) && $stable(failCol)));
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rowAddr) < ROWS) && (int'(colAddr) < COLS));
endmodule

// File: rtl/npsf_seq.sv
module npsf_seq
  import npsf_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int COLS = 20,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic [RW-1:0] rowAddr,
  output logic [CW-1:0] colAddr,
  output logic          wrEn,
  output logic          wrData,
  output logic          rdEn,
  input  logic          rdData,
  output logic          done,
  output logic          fail,
  output logic [RW-1:0] failRow,
  output logic [CW-1:0] failCol,
  output logic [4:0]    failPat
);
  strobes_t st;
  logic     lastCell;

  npsf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lastCell(lastCell), .st(st), .done(done)
  );

  npsf_dp #(.ROWS(ROWS), .COLS(COLS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .rdData(rdData),
    .rowAddr(rowAddr), .colAddr(colAddr), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .lastCell(lastCell), .fail(fail), .failRow(failRow), .failCol(failCol), .failPat(failPat)
  );
endmodule

// File: tb/tb_npsf_seq.sv
module tb_npsf_seq;
  localparam int ROWS = 5;
  localparam int COLS = 5;
  localparam int N = ROWS * COLS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] rowAddr, colAddr, failRow, failCol;
  logic wrEn, wrData, rdEn, rdData, done, fail;
  logic [4:0] failPat;

  npsf_seq #(.ROWS(ROWS), .COLS(COLS)) dut (
    .clk(clk), .rstN(rstN), .start(start), .rowAddr(rowAddr), .colAddr(colAddr),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .done(done),
    .fail(fail), .failRow(failRow), .failCol(failCol), .failPat(failPat)
  );

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  int faultMode = 0;
  int readCount = 0, writeCount = 0;
  logic mem [N];

  function automatic int lbl(input int r, input int c);
    return (c + 2 * r) % 5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // RAM model with one-cycle read latency and seeded faults
  always @(posedge clk) begin
    int a;
    a = int'(rowAddr) * COLS + int'(colAddr);
    if (wrEn) mem[a] <= wrData;
    if (rdEn) begin
      rdData <= mem[a];
      if (faultMode == 1 && a == 2 * COLS + 1 && mem[a] == 1'b0 &&
          mem[1 * COLS + 1] && mem[3 * COLS + 1] && mem[2 * COLS + 0] && mem[2 * COLS + 2])
        rdData <= 1'b1;
      if (faultMode == 2 && a == 0) rdData <= 1'b1;
      if (faultMode == 3 && a == 3 * COLS + 4) rdData <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Monitor at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (wrEn) writeCount++;
      if (wrEn && rdEn) check(1'b0, "R7 read/write clash", 1, 0);
      if (rdEn) begin
        int r, c, p, b, g, nb, bad;
        r = int'(rowAddr); c = int'(colAddr);
        nb = 5;
        p = (readCount / nb) % 16;
        b = readCount / (16 * nb);
        g = p ^ (p >> 1);
        bad = 0;
        if (lbl(r, c) != 0) bad = 1;
        if (r > 0 && mem[(r - 1) * COLS + c] != g[0]) bad = 1;
        if (r < ROWS - 1 && mem[(r + 1) * COLS + c] != g[1]) bad = 1;
        if (c > 0 && mem[r * COLS + c - 1] != g[2]) bad = 1;
        if (c < COLS - 1 && mem[r * COLS + c + 1] != g[3]) bad = 1;
        check(bad == 0, "R2/R4 neighbour pattern at read", g, p);
        check(int'(mem[r * COLS + c]) == b, "R6 base value at read", int'(mem[r * COLS + c]), b);
        readCount++;
      end
    end
  end

  function automatic int expWrites();
    int cnt [5];
    int s, total;
    for (int i = 0; i < 5; i++) cnt[i] = 0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) cnt[lbl(r, c)]++;
    total = N;
    for (int p = 1; p < 16; p++) begin
      if (p[0]) s = 3; else if (p[1]) s = 2; else if (p[2]) s = 4; else s = 1;
      total += cnt[s];
    end
    return 2 * total;
  endfunction

  task automatic runTest(input int mode);
    int w;
    faultMode = mode;
    readCount = 0;
    writeCount = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(done == 1'b0, "R9 done clears after start", int'(done), 0);
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    check(done == 1'b1, "R9 done reached", int'(done), 1);
    check(readCount == 32 * 5, "R4 read count", readCount, 160);
    check(writeCount == expWrites(), "R3/R5 write count", writeCount, expWrites());
    repeat (3) @(negedge clk);
    check(done && !wrEn && !rdEn, "R9 done holds quiet", int'({done, wrEn, rdEn}), 4);
  endtask

  initial begin
    for (int i = 0; i < N; i++) mem[i] = 1'b0;
    repeat (3) @(negedge clk);
    check(!done && !fail && !wrEn && !rdEn, "R1 reset state",
          int'({done, fail, wrEn, rdEn}), 0);
    rstN = 1'b1;
    @(negedge clk);

    runTest(0);
    check(fail == 1'b0, "R8 clean array passes", int'(fail), 0);

    runTest(1);
    check(fail == 1'b1, "R8 pattern fault flagged", int'(fail), 1);
    check(failRow == 3'd2 && failCol == 3'd1, "R8 pattern fault address",
          int'({failRow, failCol}), int'({3'd2, 3'd1}));
    check(failPat == 5'd10, "R8 pattern fault tag (base 0, index 10)", int'(failPat), 10);

    runTest(2);
    check(fail == 1'b1 && failRow == 3'd0 && failCol == 3'd0, "R8 stuck-1 address",
          int'({fail, failRow, failCol}), int'({1'b1, 6'd0}));
    check(failPat == 5'd0, "R8 first mismatch kept (base 0, index 0)", int'(failPat), 0);

    runTest(0);
    check(fail == 1'b0, "R8 fail cleared by new start", int'(fail), 0);

    runTest(3);
    check(fail == 1'b1 && failRow == 3'd3 && failCol == 3'd4, "R8 stuck-0 address",
          int'({fail, failRow, failCol}), int'({1'b1, 3'd3, 3'd4}));
    check(failPat == 5'd16, "R6 stuck-0 seen under base 1", int'(failPat), 16);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule